// File: doc/BRIEF.md
# Access-Interval Expiry Set Controller

This block keeps the replacement state of one set in an N-way set-associative cache (16 ways by default) and names the way to evict. Each way has an event counter that counts accesses to the set since that way was last hit or filled. On every hit the way keeps a running maximum of those intervals, which forms the learned threshold for its next generation. A way whose counter has gone past the threshold it was filled with, and whose confidence flag is set, is treated as dead and may be evicted ahead of the least recently used way.

The surrounding cache controller reports each access to the set (hit or miss, with the hit way) and each fill. A fill carries the threshold, the confidence flag and the program counter hash that the prediction table returned. The block presents a victim way on registered outputs, together with that way's stored hash and its current-generation maximum. The controller writes those two values back to the prediction table when it evicts the line. Tag storage, data storage and the prediction table itself live outside this block.

Top module: `ivx_set_ctrl`

## Requirements
- R1: After a synchronous reset, every counter, threshold, maximum, hash and confidence flag is zero, and the outputs show victim way WAYS-1, not expired, hash 0 and maximum 0.
- R2: Each cycle with `acc_valid` high adds one to the event counter of every way that is not filled that cycle, including the hit way, before that way's hit update. Cycles without an access leave all counters unchanged.
- R3: On a hit (`acc_valid` and `acc_hit` high) to way w, w's maximum becomes the larger of its old value and its incremented counter, and w's counter becomes 0.
- R4: A way is expired when its confidence flag is 1 and its counter is strictly greater than its loaded threshold. A counter equal to the threshold does not expire the way.
- R5: A way whose confidence flag is 0 never expires, however large its counter becomes.
- R6: Event counters and maxima saturate at 2^CNT_W-1 (15 by default) and never wrap.
- R7: When one or more ways are expired, the victim is the expired way with the lowest index, and `victim_exp` is 1.
- R8: When no way is expired, the victim is the least recently used way and `victim_exp` is 0. Hits and fills make a way most recently used. The reset order puts way 0 as most recent and way WAYS-1 as least recent.
- R9: A fill to way w loads w's threshold, confidence and hash from `fill_thr`, `fill_conf` and `fill_hash`, and clears w's counter and maximum. A fill takes priority over a hit to the same way in the same cycle.
- R10: `victim_way`, `victim_exp`, `victim_hash` and `victim_max` are registered. They show the choice made from the state as it stood after the previous clock edge, so a change of state reaches them one cycle after it is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access to this set occurs this cycle |
| acc_hit | input | 1 | The access hit (qualified by acc_valid) |
| acc_way | input | $clog2(WAYS) | Way that hit |
| fill_valid | input | 1 | A line is placed into fill_way this cycle |
| fill_way | input | $clog2(WAYS) | Way being filled |
| fill_thr | input | CNT_W | Learned threshold loaded on fill |
| fill_conf | input | 1 | Confidence flag loaded on fill |
| fill_hash | input | HASH_W | Program counter hash stored on fill |
| victim_way | output | $clog2(WAYS) | Way chosen for eviction |
| victim_exp | output | 1 | Victim was chosen because it expired |
| victim_hash | output | HASH_W | Stored hash of the victim way |
| victim_max | output | CNT_W | Current-generation maximum interval of the victim |

## Verification
The assertions assume that reset is held for at least one clock edge before any traffic. They also assume that `acc_way` and `fill_way` always name an existing way and that `acc_hit` is only acted on together with `acc_valid`. The stimulus drives only in-range way indices and raises each access or fill for exactly one cycle, with idle cycles in between. Accesses and fills are never issued in the same cycle, so the hit and saturation properties, which exclude fill cycles, are exercised on every hit the bench issues.

// File: rtl/ivx_pkg.sv
package ivx_pkg;
  // Per-way update selected each cycle by the set controller.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,  // no access to the set
    OP_BUMP = 2'd1,  // access to the set, this way not hit
    OP_HIT  = 2'd2,  // this way hit: record interval, restart
    OP_FILL = 2'd3   // new line placed in this way
  } way_op_e;
endpackage

// File: rtl/ivx_way_state.sv
module ivx_way_state
  import ivx_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int HASH_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  way_op_e           op,
  input  logic [CNT_W-1:0]  fill_thr,
  input  logic              fill_conf,
  input  logic [HASH_W-1:0] fill_hash,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cur_max,
  output logic [HASH_W-1:0] hash,
  output logic              expired
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, thr_q, max_q, bumped;
  logic [HASH_W-1:0] hash_q;
  logic conf_q;

  // Saturating increment of the event counter.
  assign bumped = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      thr_q  <= '0;
      max_q  <= '0;
      conf_q <= 1'b0;
      hash_q <= '0;
    end else begin
      case (op)
        OP_BUMP: cnt_q <= bumped;
        OP_HIT: begin
          cnt_q <= '0;
          if (bumped > max_q) max_q <= bumped;
        end
        OP_FILL: begin
          cnt_q  <= '0;
          max_q  <= '0;
          thr_q  <= fill_thr;
          conf_q <= fill_conf;
          hash_q <= fill_hash;
        end
        default: ;
      endcase
    end
  end

  assign cnt     = cnt_q;
  assign cur_max = max_q;
  assign hash    = hash_q;
  assign expired = conf_q && (cnt_q > thr_q);
endmodule

// File: rtl/ivx_lru.sv
module ivx_lru #(
  parameter int WAYS = 16,
  localparam int IW  = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_way,
  output logic [IW-1:0] lru_way
);
  // Rank 0 is most recent, rank WAYS-1 is least recent.
  logic [IW-1:0] rank_q [WAYS];
  logic [IW-1:0] touched_rank;

  assign touched_rank = rank_q[touch_way];

  for (genvar g = 0; g < WAYS; g++) begin : g_rank
    always_ff @(posedge clk) begin
      if (rst) begin
        rank_q[g] <= IW'(g);
      end else if (touch) begin
        if (touch_way == IW'(g))
          rank_q[g] <= '0;
        else if (rank_q[g] < touched_rank)
          rank_q[g] <= rank_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (rank_q[i] == IW'(WAYS - 1)) lru_way = IW'(i);
  end
endmodule

// File: rtl/ivx_pick.sv
module ivx_pick #(
  parameter int WAYS = 16,
  localparam int IW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] exp_vec,
  input  logic [IW-1:0]   lru_way,
  output logic [IW-1:0]   pick_way,
  output logic            pick_exp
);
  // Lowest-index expired way wins; otherwise the LRU way.
  always_comb begin
    pick_way = lru_way;
    pick_exp = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (exp_vec[i]) begin
        pick_way = IW'(i);
        pick_exp = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivx_set_ctrl.sv
module ivx_set_ctrl
  import ivx_pkg::*;
#(
  parameter int WAYS   = 16,
  parameter int CNT_W  = 4,
  parameter int HASH_W = 8,
  localparam int IW    = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_hit,
  input  logic [IW-1:0]     acc_way,
  input  logic              fill_valid,
  input  logic [IW-1:0]     fill_way,
  input  logic [CNT_W-1:0]  fill_thr,
  input  logic              fill_conf,
  input  logic [HASH_W-1:0] fill_hash,
  output logic [IW-1:0]     victim_way,
  output logic              victim_exp,
  output logic [HASH_W-1:0] victim_hash,
  output logic [CNT_W-1:0]  victim_max
);
  logic [CNT_W-1:0]  cnt_a  [WAYS];
  logic [CNT_W-1:0]  max_a  [WAYS];
  logic [HASH_W-1:0] hash_a [WAYS];
  way_op_e           op_a   [WAYS];
  logic [WAYS-1:0]   exp_vec;
  logic [WAYS*CNT_W-1:0] cnt_flat, max_flat;

  logic          touch;
  logic [IW-1:0] touch_way, lru_way, pick_way;
  logic          pick_exp;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_comb begin
      if (fill_valid && fill_way == IW'(g))
        op_a[g] = OP_FILL;
      else if (acc_valid && acc_hit && acc_way == IW'(g))
        op_a[g] = OP_HIT;
      else if (acc_valid)
        op_a[g] = OP_BUMP;
      else
        op_a[g] = OP_HOLD;
    end

    ivx_way_state #(.CNT_W(CNT_W), .HASH_W(HASH_W)) u_state (
      .clk      (clk),
      .rst      (rst),
      .op       (op_a[g]),
      .fill_thr (fill_thr),
      .fill_conf(fill_conf),
      .fill_hash(fill_hash),
      .cnt      (cnt_a[g]),
      .cur_max  (max_a[g]),
      .hash     (hash_a[g]),
      .expired  (exp_vec[g])
    );

    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_a[g];
    assign max_flat[g*CNT_W +: CNT_W] = max_a[g];
  end

  assign touch     = fill_valid || (acc_valid && acc_hit);
  assign touch_way = fill_valid ? fill_way : acc_way;

  ivx_lru #(.WAYS(WAYS)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .touch    (touch),
    .touch_way(touch_way),
    .lru_way  (lru_way)
  );

  ivx_pick #(.WAYS(WAYS)) u_pick (
    .exp_vec (exp_vec),
    .lru_way (lru_way),
    .pick_way(pick_way),
    .pick_exp(pick_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_way  <= IW'(WAYS - 1);
      victim_exp  <= 1'b0;
      victim_hash <= '0;
      victim_max  <= '0;
    end else begin
      victim_way  <= pick_way;
      victim_exp  <= pick_exp;
      victim_hash <= hash_a[pick_way];
      victim_max  <= max_a[pick_way];
    end
  end
endmodule

// File: rtl/ivx_set_ctrl_chk.sv
module ivx_set_ctrl_chk #(
  parameter int WAYS   = 16,
  parameter int CNT_W  = 4,
  parameter int HASH_W = 8,
  localparam int IW    = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_hit,
  input logic [IW-1:0]     acc_way,
  input logic              fill_valid,
  input logic [IW-1:0]     fill_way,
  input logic [IW-1:0]     victim_way,
  input logic              victim_exp,
  input logic [HASH_W-1:0] victim_hash,
  input logic [CNT_W-1:0]  victim_max,
  input logic [WAYS*CNT_W-1:0] cnt_flat,
  input logic [WAYS*CNT_W-1:0] max_flat,
  input logic [WAYS-1:0]   exp_vec
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] slot(input logic [WAYS*CNT_W-1:0] v,
                                            input logic [IW-1:0] w);
    return v[w*CNT_W +: CNT_W];
  endfunction

  logic [WAYS-1:0] exp_d, below;
  always_ff @(posedge clk) exp_d <= exp_vec;
  assign below = (WAYS'(1) << victim_way) - WAYS'(1);

  // R1: outputs come out of reset at their defined values
  a_r1_reset_out: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (victim_way == IW'(WAYS - 1) && !victim_exp &&
                    victim_hash == '0 && victim_max == '0));

  // R9: a filled way starts with a cleared counter and maximum
  a_r9_fill_clears: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (slot(cnt_flat, $past(fill_way)) == '0 &&
                    slot(max_flat, $past(fill_way)) == '0));

  // R3: a hit restarts the counter of the hit way
  a_r3_hit_restart: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit && !fill_valid) |=> slot(cnt_flat, $past(acc_way)) == '0);

  // R3: a hit never lowers the maximum and leaves it non-zero
  a_r3_max_grows: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit && !fill_valid) |=>
      (slot(max_flat, $past(acc_way)) >= $past(slot(max_flat, acc_way)) &&
       slot(max_flat, $past(acc_way)) != '0));

  // R6: a full counter stays full on further non-hit accesses (way 0)
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !fill_valid && !(acc_hit && acc_way == '0) &&
     slot(cnt_flat, '0) == CNT_TOP) |=> slot(cnt_flat, '0) == CNT_TOP);

  // R7: an expired victim was expired and had no lower expired neighbour
  a_r7_lowest_expired: assert property (@(posedge clk) disable iff (rst)
    victim_exp |-> (exp_d[victim_way] && (exp_d & below) == '0));

  // R8: a non-expired victim means nothing was expired
  a_r8_fallback_clean: assert property (@(posedge clk) disable iff (rst)
    (!victim_exp && !$past(rst)) |-> exp_d == '0);

  logic unused_ok;
  assign unused_ok = ^victim_hash;
endmodule

bind ivx_set_ctrl ivx_set_ctrl_chk #(
  .WAYS(WAYS), .CNT_W(CNT_W), .HASH_W(HASH_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_hit    (acc_hit),
  .acc_way    (acc_way),
  .fill_valid (fill_valid),
  .fill_way   (fill_way),
  .victim_way (victim_way),
  .victim_exp (victim_exp),
  .victim_hash(victim_hash),
  .victim_max (victim_max),
  .cnt_flat   (cnt_flat),
  .max_flat   (max_flat),
  .exp_vec    (exp_vec)
);

// File: tb/ivx_set_ctrl_bench.sv
`timescale 1ns/1ps
module ivx_set_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0, acc_hit = 1'b0, fill_valid = 1'b0, fill_conf = 1'b0;
  logic [3:0] acc_way = '0, fill_way = '0, fill_thr = '0;
  logic [7:0] fill_hash = '0;
  logic [3:0] victim_way;
  logic       victim_exp;
  logic [7:0] victim_hash;
  logic [3:0] victim_max;

  int checks = 0, errors = 0, pcnt = 0;
  bit done = 0;

  typedef struct {
    string tag;
    int    way;
    bit    ex;
    int    hash;
    int    mx;
    int    due;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) pcnt <= pcnt + 1;

  ivx_set_ctrl u_ivx_set_ctrl (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_way(acc_way),
    .fill_valid(fill_valid), .fill_way(fill_way), .fill_thr(fill_thr),
    .fill_conf(fill_conf), .fill_hash(fill_hash),
    .victim_way(victim_way), .victim_exp(victim_exp),
    .victim_hash(victim_hash), .victim_max(victim_max)
  );

  // Monitor: pops one expected item per falling edge once it is due.
  always @(negedge clk) begin : mon
    item_t it;
    if (sb.size() > 0 && pcnt >= sb[0].due) begin
      it = sb.pop_front();
      checks++;
      if ({victim_way, victim_exp, victim_hash, victim_max} !==
          {4'(it.way), it.ex, 8'(it.hash), 4'(it.mx)}) begin
        errors++;
        $display("FAIL %s: got way=%0d exp=%0b hash=%0h max=%0d, want way=%0d exp=%0b hash=%0h max=%0d",
                 it.tag, victim_way, victim_exp, victim_hash, victim_max,
                 it.way, it.ex, it.hash, it.mx);
      end
    end
  end

  function automatic item_t mk(string tag, int way, bit ex, int hash, int mx, int due);
    item_t it;
    it.tag = tag; it.way = way; it.ex = ex; it.hash = hash; it.mx = mx; it.due = due;
    return it;
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_miss(int n);
    repeat (n) begin
      @(negedge clk); acc_valid = 1'b1; acc_hit = 1'b0;
      @(negedge clk); acc_valid = 1'b0;
    end
  endtask

  task automatic do_hit(int w);
    @(negedge clk); acc_valid = 1'b1; acc_hit = 1'b1; acc_way = 4'(w);
    @(negedge clk); acc_valid = 1'b0; acc_hit = 1'b0;
  endtask

  task automatic do_fill(int w, int thr, bit conf, int hash);
    @(negedge clk);
    fill_valid = 1'b1; fill_way = 4'(w); fill_thr = 4'(thr);
    fill_conf = conf; fill_hash = 8'(hash);
    @(negedge clk); fill_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side of the scoreboard: called at the falling edge after the last
  // stimulus was removed; the registered outputs settle one rising edge later.
  task automatic expect_out(string tag, int way, bit ex, int hash, int mx);
    sb.push_back(mk(tag, way, ex, hash, mx, pcnt + 1));
    wait (sb.size() == 0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, want completion");
      finish_run();
    end
  end

  initial begin : drive
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1 reset state", 15, 0, 0, 0);

    do_fill(3, 2, 1, 'hA5);
    expect_out("R9 fill keeps LRU victim R8", 15, 0, 0, 0);
    do_miss(2);
    expect_out("R4 counter equal to threshold", 15, 0, 0, 0);
    do_miss(1);
    expect_out("R4 counter above threshold", 3, 1, 'hA5, 0);
    do_hit(3);
    expect_out("R3 hit restarts counter", 15, 0, 0, 0);
    do_miss(3);
    expect_out("R3 max recorded as 4", 3, 1, 'hA5, 4);

    do_fill(3, 15, 0, 'h3C);
    do_miss(20);
    expect_out("R5 no confidence never expires", 15, 0, 0, 0);

    do_fill(7, 1, 1, 'h77);
    do_fill(9, 1, 1, 'h99);
    do_miss(2);
    expect_out("R7 lowest expired wins", 7, 1, 'h77, 0);
    do_hit(7);
    expect_out("R7 R2 hit bumps other ways", 9, 1, 'h99, 0);

    do_fill(7, 0, 0, 'h70);
    do_fill(9, 0, 0, 'h90);
    do_fill(2, 14, 1, 'h22);
    do_miss(14);
    expect_out("R6 counter at 14 not expired", 15, 0, 0, 0);
    do_miss(1);
    expect_out("R6 counter at 15 expired", 2, 1, 'h22, 0);
    do_miss(5);
    do_hit(2);
    do_miss(15);
    expect_out("R6 saturated interval recorded", 2, 1, 'h22, 15);

    do_fill(2, 0, 0, 'h20);
    do_hit(15);
    expect_out("R8 LRU after hit on 15", 14, 0, 0, 0);
    do_hit(14);
    expect_out("R8 LRU after hit on 14", 13, 0, 0, 0);

    do_fill(4, 3, 1, 'h44);
    idle(10);
    expect_out("R2 idle cycles do not count", 13, 0, 0, 0);
    do_miss(3);
    expect_out("R2 three accesses counted", 13, 0, 0, 0);
    do_miss(1);
    expect_out("R2 fourth access expires", 4, 1, 'h44, 0);

    // R10: one cycle of output latency after a hit on the expired way
    @(negedge clk); acc_valid = 1'b1; acc_hit = 1'b1; acc_way = 4'd4;
    sb.push_back(mk("R10 output still old", 4, 1, 'h44, 0, pcnt + 1));
    sb.push_back(mk("R10 output updated", 13, 0, 0, 0, pcnt + 2));
    @(negedge clk); acc_valid = 1'b0; acc_hit = 1'b0;
    wait (sb.size() == 0);

    idle(2);
    done = 1;
    finish_run();
  end
endmodule